// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Sensing

A 32-pin general-purpose I/O port on a single-cycle register bus. Each pin carries a stored output value and a direction bit: when the direction bit is 1 the pin drives its stored value, and when it is 0 the pin is an input. Every pad input passes through a two-flop synchroniser. The synchronised level can be read at any time, whatever the direction.

Each pin has an interrupt sense condition: low level, high level, rising edge or falling edge. A separate per-pin either-edge bit replaces that condition with detection of both edges. A detected event sets a sticky status bit, and software clears the bit by writing a one to it. Status bits are combined with a per-pin enable mask into one interrupt line. A pin that should raise no interrupt is given a mask bit of 0.

The data register also has write-only set, clear and toggle aliases. These change only the bits written as 1, in a single bus write, without a read-modify-write. Writes take effect on the clock edge where the write enable is sampled. Reads are combinational from the address.

Register word addresses:

| Address | Register |
|---|---|
| 0 | data |
| 1 | direction |
| 2 | pad level (read-only) |
| 3 | sense condition for pins 0 to 15 |
| 4 | sense condition for pins 16 to 31 |
| 5 | interrupt mask |
| 6 | interrupt status |
| 7 | either-edge select |
| 8 | set alias |
| 9 | clear alias |
| 10 | toggle alias |

Unused addresses read 0.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the data, direction, mask and either-edge registers read 0. Both sense-condition registers read 0. pad_oe is 0 and irq is 0.
- R2: A write to address 0 stores the data register, and the data register reads back the stored value. pad_out equals the data register. A write to address 1 stores the direction register, and pad_oe equals the direction register.
- R3: A write to address 8 sets, a write to address 9 clears, and a write to address 10 inverts the data bits written as 1. Data bits written as 0 are left unchanged. Addresses 8, 9 and 10 read as 0.
- R4: Address 2 returns pad_in delayed by two clock edges, for input and output pins alike.
- R5: The 2-bit sense code of pin i sits at bits [2i+1:2i] of address 3 for i < 16, and of address 4 for pin i-16. The codes are 0 for low level, 1 for high level, 2 for rising edge and 3 for falling edge. An edge event sets its status bit at the third clock edge after the pad changes, and a held level does not flag again.
- R6: In a level mode the status bit cannot be cleared while the level persists. It still reads 1 after a clear.
- R7: When a pin's bit at address 7 is 1, both edges flag, whatever its sense code, and a held level does not flag.
- R8: Writing address 6 clears each status bit written as 1 and leaves bits written as 0 untouched. An event in the same cycle as a clear keeps the bit set.
- R9: Status bits set whether or not the pin is masked. irq is the OR over all pins of status AND mask, and it follows mask and status writes combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write enable, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output levels |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
- **Register writes:** a write appears on readback, pad_out and pad_oe right after the clock edge that samples it. The bench therefore drives each write on a falling edge and reads on the next falling edge.
- **Pad level:** a pad change reaches the pad-level register after two rising edges. The bench checks that the old value is still present after one edge and the new value after two.
- **Status bits:** a status bit sets at the third rising edge after a pad change, so every status check waits three edges. Where the timing itself is the point, the bench also confirms the bit is still clear one edge earlier.
- **Interrupt line:** irq is combinational from the status and mask registers. It is checked on the same falling edge as the register write that changes it.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] A_DATA   = 4'd0;
  localparam logic [REG_AW-1:0] A_DIR    = 4'd1;
  localparam logic [REG_AW-1:0] A_PAD    = 4'd2;
  localparam logic [REG_AW-1:0] A_CONDL  = 4'd3;
  localparam logic [REG_AW-1:0] A_CONDH  = 4'd4;
  localparam logic [REG_AW-1:0] A_MASK   = 4'd5;
  localparam logic [REG_AW-1:0] A_STAT   = 4'd6;
  localparam logic [REG_AW-1:0] A_BOTH   = 4'd7;
  localparam logic [REG_AW-1:0] A_SET    = 4'd8;
  localparam logic [REG_AW-1:0] A_CLR    = 4'd9;
  localparam logic [REG_AW-1:0] A_TGL    = 4'd10;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;
endpackage

// File: rtl/gpio_irq_rst_sync.sv
`timescale 1ns/1ps
module gpio_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage_q;
  logic core_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      core_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      core_q  <= stage_q;
    end
  end

  assign rst_core_n = core_q;
endmodule

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PINS-1:0]   level,
  input  logic [2*N_PINS-1:0] sense,
  input  logic [N_PINS-1:0]   both_edges,
  output logic [N_PINS-1:0]   event_v
);
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] prev_n;

  assign prev_n = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_n;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic rise;
    logic fall;
    assign rise = level[i] & ~prev_q[i];
    assign fall = ~level[i] & prev_q[i];

    always_comb begin
      if (both_edges[i]) begin
        event_v[i] = rise | fall;
      end else begin
        case (sense_e'(sense[2*i +: 2]))
          SENSE_LOW:  event_v[i] = ~level[i];
          SENSE_HIGH: event_v[i] = level[i];
          SENSE_RISE: event_v[i] = rise;
          default:    event_v[i] = fall;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_AW-1:0]   addr,
  input  logic                we,
  input  logic [N_PINS-1:0]   wdata,
  input  logic [N_PINS-1:0]   pad_sync,
  input  logic [N_PINS-1:0]   event_v,
  output logic [N_PINS-1:0]   rdata,
  output logic [N_PINS-1:0]   data_q,
  output logic [N_PINS-1:0]   dir_q,
  output logic [2*N_PINS-1:0] sense_q,
  output logic [N_PINS-1:0]   both_q,
  output logic [N_PINS-1:0]   mask_q,
  output logic [N_PINS-1:0]   status_q
);
  localparam int SW = 2 * N_PINS;

  logic [N_PINS-1:0] data_n;
  logic [N_PINS-1:0] status_n;
  logic [N_PINS-1:0] clr_v;
  logic [SW-1:0]     sense_n;
  logic data_en, dir_en, sense_en, both_en, mask_en;

  always_comb begin
    data_en  = we && (addr == A_DATA || addr == A_SET || addr == A_CLR || addr == A_TGL);
    dir_en   = we && (addr == A_DIR);
    sense_en = we && (addr == A_CONDL || addr == A_CONDH);
    both_en  = we && (addr == A_BOTH);
    mask_en  = we && (addr == A_MASK);

    case (addr)
      A_SET:   data_n = data_q | wdata;
      A_CLR:   data_n = data_q & ~wdata;
      A_TGL:   data_n = data_q ^ wdata;
      default: data_n = wdata;
    endcase

    sense_n = sense_q;
    if (addr == A_CONDH) sense_n[SW-1:N_PINS] = wdata;
    else                 sense_n[N_PINS-1:0]  = wdata;

    clr_v    = (we && addr == A_STAT) ? wdata : '0;
    status_n = (status_q & ~clr_v) | event_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      sense_q  <= '0;
      both_q   <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (data_en)  data_q  <= data_n;
      if (dir_en)   dir_q   <= wdata;
      if (sense_en) sense_q <= sense_n;
      if (both_en)  both_q  <= wdata;
      if (mask_en)  mask_q  <= wdata;
      status_q <= status_n;
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = data_q;
      A_DIR:   rdata = dir_q;
      A_PAD:   rdata = pad_sync;
      A_CONDL: rdata = sense_q[N_PINS-1:0];
      A_CONDH: rdata = sense_q[SW-1:N_PINS];
      A_MASK:  rdata = mask_q;
      A_STAT:  rdata = status_q;
      A_BOTH:  rdata = both_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [N_PINS-1:0]   bus_wdata,
  output logic [N_PINS-1:0]   bus_rdata,
  input  logic [N_PINS-1:0]   pad_in,
  output logic [N_PINS-1:0]   pad_out,
  output logic [N_PINS-1:0]   pad_oe,
  output logic                irq
);
  logic                rst_core_n;
  logic [N_PINS-1:0]   pad_sync;
  logic [N_PINS-1:0]   event_v;
  logic [N_PINS-1:0]   data_w;
  logic [N_PINS-1:0]   dir_w;
  logic [2*N_PINS-1:0] sense_w;
  logic [N_PINS-1:0]   both_w;
  logic [N_PINS-1:0]   mask_w;
  logic [N_PINS-1:0]   status_w;

  gpio_irq_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  gpio_irq_sync #(.WIDTH(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .async_in(pad_in), .sync_out(pad_sync)
  );

  gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
    .clk(clk), .rst_n(rst_core_n), .level(pad_sync), .sense(sense_w),
    .both_edges(both_w), .event_v(event_v)
  );

  gpio_irq_regs #(.N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .pad_sync(pad_sync), .event_v(event_v),
    .rdata(bus_rdata), .data_q(data_w), .dir_q(dir_w), .sense_q(sense_w),
    .both_q(both_w), .mask_q(mask_w), .status_q(status_w)
  );

  assign pad_out = data_w;
  assign pad_oe  = dir_w;
  assign irq     = |(status_w & mask_w);
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [N_PINS-1:0] bus_wdata,
  input logic [N_PINS-1:0] pad_in,
  input logic [N_PINS-1:0] pad_oe,
  input logic              irq,
  input logic [N_PINS-1:0] data_w,
  input logic [N_PINS-1:0] mask_w,
  input logic [N_PINS-1:0] status_w,
  input logic [N_PINS-1:0] pad_sync
);
  logic [1:0]        age_q;
  logic [N_PINS-1:0] w1c_v;

  assign w1c_v = (bus_we && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)        age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($past(bus_we) && $past(bus_addr) == A_SET) |-> data_w == ($past(data_w) | $past(bus_wdata)));

  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($past(bus_we) && $past(bus_addr) == A_CLR) |-> data_w == ($past(data_w) & ~$past(bus_wdata)));

  assert_tgl_alias_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($past(bus_we) && $past(bus_addr) == A_TGL) |-> data_w == ($past(data_w) ^ $past(bus_wdata)));

  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($past(bus_we) && $past(bus_addr) == A_DIR) |-> pad_oe == $past(bus_wdata));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (age_q != 2'd0) |-> (($past(status_w) & ~status_w & ~$past(w1c_v)) == '0));

  assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> ((status_w & mask_w) != '0));

  assert_pad_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (age_q == 2'd3) |-> pad_sync == $past(pad_in, 2));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_oe(pad_oe), .irq(irq),
  .data_w(data_w), .mask_w(mask_w), .status_w(status_w), .pad_sync(pad_sync)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
  localparam logic [3:0] A_DATA = 4'd0, A_DIR = 4'd1, A_PAD = 4'd2, A_CONDL = 4'd3,
                         A_CONDH = 4'd4, A_MASK = 4'd5, A_STAT = 4'd6, A_BOTH = 4'd7,
                         A_SET = 4'd8, A_CLR = 4'd9, A_TGL = 4'd10;
  localparam logic [31:0] COND_ALL_HIGH = 32'h5555_5555;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic flush_status();
    logic [31:0] v;
    pad_in = '0;
    settle();
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v);
    check("R8 status flushed", v, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_DATA, v);  check("R1 data", v, 32'h0);
    rd(A_DIR, v);   check("R1 dir", v, 32'h0);
    rd(A_MASK, v);  check("R1 mask", v, 32'h0);
    rd(A_BOTH, v);  check("R1 both", v, 32'h0);
    rd(A_CONDL, v); check("R1 condl", v, 32'h0);
    rd(A_CONDH, v); check("R1 condh", v, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_STAT, v);  check("R5 low-level default flags low pads", v, 32'hFFFF_FFFF);
    wr(A_CONDL, COND_ALL_HIGH);
    wr(A_CONDH, COND_ALL_HIGH);
    flush_status();
  endtask

  task automatic t_data();
    logic [31:0] v;
    wr(A_DATA, 32'hA5A5_0F0F);
    rd(A_DATA, v); check("R2 data readback", v, 32'hA5A5_0F0F);
    check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    wr(A_DIR, 32'hFFFF_0000);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(A_DIR, v); check("R2 dir readback", v, 32'hFFFF_0000);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(A_SET, 32'h0000_00F0);
    rd(A_DATA, v); check("R3 set alias", v, 32'hA5A5_0FFF);
    wr(A_CLR, 32'hA000_000F);
    rd(A_DATA, v); check("R3 clear alias", v, 32'h05A5_0FF0);
    wr(A_TGL, 32'hFFFF_0000);
    rd(A_DATA, v); check("R3 toggle alias", v, 32'hFA5A_0FF0);
    check("R3 pad_out after aliases", pad_out, 32'hFA5A_0FF0);
    rd(A_SET, v); check("R3 set reads zero", v, 32'h0);
    rd(A_CLR, v); check("R3 clear reads zero", v, 32'h0);
    rd(A_TGL, v); check("R3 toggle reads zero", v, 32'h0);
  endtask

  task automatic t_pad();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 32'h1234_5678;
    @(negedge clk);
    rd(A_PAD, v); check("R4 pad after one edge", v, 32'h0);
    @(negedge clk);
    rd(A_PAD, v); check("R4 pad after two edges, any direction", v, 32'h1234_5678);
    flush_status();
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(A_CONDL, 32'h5555_5795);
    @(negedge clk);
    pad_in = 32'h0000_0018;
    repeat (2) @(negedge clk);
    rd(A_STAT, v); check("R5 rise not yet at second edge", v, 32'h0);
    @(negedge clk);
    rd(A_STAT, v); check("R5 rise flags pin3 only", v, 32'h0000_0008);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, v); check("R5 held high no reflag", v, 32'h0);
    pad_in = 32'h0;
    settle();
    rd(A_STAT, v); check("R5 fall flags pin4 only", v, 32'h0000_0010);
    wr(A_CONDH, 32'h9555_5555);
    pad_in = 32'h8000_0000;
    settle();
    rd(A_STAT, v); check("R5 upper register rise pin31", v, 32'h8000_0010);
    wr(A_STAT, 32'h8000_0010);
    rd(A_STAT, v); check("R5 pin31 held no reflag", v, 32'h0);
    wr(A_CONDL, COND_ALL_HIGH);
    wr(A_CONDH, COND_ALL_HIGH);
    flush_status();
  endtask

  task automatic t_level();
    logic [31:0] v;
    pad_in = 32'h0000_0100;
    settle();
    rd(A_STAT, v); check("R6 high level flags", v, 32'h0000_0100);
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT, v); check("R6 R8 high level survives clear", v, 32'h0000_0100);
    pad_in = 32'h0;
    settle();
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT, v); check("R6 clear after level gone", v, 32'h0);
    wr(A_CONDL, 32'h5551_5555);
    settle();
    rd(A_STAT, v); check("R6 low level flags pin9", v, 32'h0000_0200);
    wr(A_STAT, 32'h0000_0200);
    rd(A_STAT, v); check("R6 low level survives clear", v, 32'h0000_0200);
    pad_in = 32'h0000_0200;
    settle();
    wr(A_STAT, 32'h0000_0200);
    rd(A_STAT, v); check("R6 low level cleared when high", v, 32'h0);
    wr(A_CONDL, COND_ALL_HIGH);
    flush_status();
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(A_BOTH, 32'h0010_0000);
    pad_in = 32'h0010_0000;
    settle();
    rd(A_STAT, v); check("R7 either-edge rise", v, 32'h0010_0000);
    wr(A_STAT, 32'h0010_0000);
    rd(A_STAT, v); check("R7 overrides high level", v, 32'h0);
    pad_in = 32'h0;
    settle();
    rd(A_STAT, v); check("R7 either-edge fall", v, 32'h0010_0000);
    wr(A_BOTH, 32'h0);
    flush_status();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pad_in = 32'h0000_0020;
    settle();
    rd(A_STAT, v); check("R9 status sets while masked", v, 32'h0000_0020);
    check("R9 irq low while masked", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h0000_0020);
    check("R9 irq high when enabled", {31'b0, irq}, 32'h1);
    wr(A_MASK, 32'h0000_0040);
    check("R9 irq low for other pin mask", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h0000_0020);
    pad_in = 32'h0;
    settle();
    check("R9 irq sticky", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'hFFFF_FFDF);
    rd(A_STAT, v); check("R8 zero bits untouched", v, 32'h0000_0020);
    wr(A_STAT, 32'h0000_0020);
    rd(A_STAT, v); check("R8 one clears", v, 32'h0);
    check("R9 irq drops on clear", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_data();
    t_alias();
    t_pad();
    t_edge();
    t_level();
    t_both();
    t_irq();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule